// File: doc/BRIEF.md
# Timed Test Coprocessor

This block sits on the coprocessor command port of a processor and answers to coprocessor numbers 4 and 5. It holds sixteen general registers that register-transfer commands read and write. Number 4 also accepts memory load and store transfers of one or two words. The address side of those transfers belongs to the processor, so only the data words cross this port. Data-operation commands act on time. They can stall the processor for a programmed number of cycles, schedule an active-low fast or normal interrupt request after a programmed delay, release either request, and copy a free-running cycle counter into a register.

The processor presents one command as a single-cycle `cmd_valid` pulse in cycle T, with its type, coprocessor number, instruction word and write data. The block answers in cycle T+1 with `cmd_accept` or `cmd_reject`. It reports completion with `cmd_done` and shows `cmd_busy` while a multi-cycle command is still running. A rejected command sends the processor down its undefined-instruction path.

Top module: `tcop_timed`

## Requirements
- R1: After reset, `fiq_n` and `irq_n` are high, `cmd_busy`, `cmd_done`, `cmd_accept` and `cmd_reject` are low, and every register reads back as zero.
- R2: A register-transfer command (type 0 = write register, type 1 = read register) on number 4 or 5 selects its register with instruction bits 19:16. A write stores `cmd_wdata`. A read shows the register on `cmd_rdata` in cycle T+1, with `cmd_done` high in that same cycle.
- R3: Load (type 2) and store (type 3) select their register with instruction bits 15:12. When instruction bit 22 is clear, a load stores `cmd_wdata` and a store shows the register on `cmd_rdata` in cycle T+1, with `cmd_done` high in that cycle.
- R4: When instruction bit 22 is set, the load or store moves two words. The second word uses the next register index, modulo 16. `cmd_busy` is high in cycle T+1, where a load takes its second word from `cmd_wdata` and a store shows its first word. `cmd_done` is high in cycle T+2, where a store shows its second word.
- R5: A data operation (type 4) takes its opcode from bits 23:20 and its operand register from bits 3:0. Opcode 0 on number 4 or 5 stalls for N cycles, where N is the operand register's value. `cmd_busy` is high from cycle T+1 until `cmd_done`, which rises in cycle T+max(N,1).
- R6: Opcode 1 on number 5 drives `fiq_n` low from cycle T+1+N. The line then stays low until it is released.
- R7: Opcode 2 on number 5 drives `irq_n` low from cycle T+1+N in the same way.
- R8: A new delayed-request command while one is pending restarts that request's countdown from the new command.
- R9: Opcode 3 on number 5 raises `fiq_n`, and opcode 4 raises `irq_n`, from cycle T+1. Each also cancels any pending countdown of its own request.
- R10: Opcode 5 on number 5 writes the cycle counter into the operand register. The counter advances by one every cycle, so two snapshots differ by exactly the number of cycles between their command cycles.
- R11: The following commands pulse `cmd_reject` without `cmd_done` or `cmd_accept` in cycle T+1, and change no register or request line:
  - any command to a number other than 4 or 5;
  - a load or store on number 5;
  - a type code of 5 to 7;
  - a data operation on number 4 with an opcode other than 0;
  - a data operation on number 5 with an opcode above 5.
- R12: Every accepted command pulses `cmd_accept` for one cycle in cycle T+1.
- R13: A `cmd_valid` pulse that arrives while a command is still in progress, including its done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_type | input | 3 | 0 write reg, 1 read reg, 2 load, 3 store, 4 data operation |
| cmd_cpnum | input | 4 | Coprocessor number |
| cmd_instr | input | 32 | Instruction word |
| cmd_wdata | input | DW | Data from the processor |
| cmd_rdata | output | DW | Data to the processor |
| cmd_busy | output | 1 | Command still running |
| cmd_done | output | 1 | Command complete |
| cmd_accept | output | 1 | Command accepted |
| cmd_reject | output | 1 | Command rejected |
| fiq_n | output | 1 | Active-low fast interrupt request |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default data width of 32, so the counter, the stall arithmetic and the countdowns all run at full word width. Stall and delay values stay small enough that the exact cycle a request line falls or a stall ends is counted directly. With these values, a zero delay, a restarted countdown, a release that lands before expiry and a two-word transfer that wraps from register 15 to register 0 can all be reached. Random register and transfer traffic is compared against a bench model of the register file.

// File: rtl/tcop_timed.sv
module tcop_timed #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_type,
  input  logic [3:0]    cmd_cpnum,
  input  logic [31:0]   cmd_instr,
  input  logic [DW-1:0] cmd_wdata,
  output logic [DW-1:0] cmd_rdata,
  output logic          cmd_busy,
  output logic          cmd_done,
  output logic          cmd_accept,
  output logic          cmd_reject,
  output logic          fiq_n,
  output logic          irq_n
);
  localparam int NREG = 16;
  localparam int IW = $clog2(NREG);
  localparam logic [2:0] T_WR = 3'd0, T_RD = 3'd1, T_LD = 3'd2, T_ST = 3'd3, T_OP = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RESP, S_BEAT2, S_STALL} st_t;
  st_t st;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] cnt, fin, fcnt, icnt;
  logic          fpend, ipend, acc_q, rej_q, ld_q;
  logic [IW-1:0] nidx;

  wire [3:0]    op   = cmd_instr[23:20];
  wire [IW-1:0] ra   = cmd_instr[19:16];
  wire [IW-1:0] rl   = cmd_instr[15:12];
  wire [IW-1:0] ro   = cmd_instr[3:0];
  wire          lng  = cmd_instr[22];
  wire          cp4  = cmd_cpnum == 4'd4;
  wire          cp5  = cmd_cpnum == 4'd5;
  wire          go   = cmd_valid && st == S_IDLE;
  wire [DW-1:0] opnd = regs[ro];
  wire [DW-1:0] diff = cnt - fin;
  wire          reached = !diff[DW-1];

  logic unused_bits;
  assign unused_bits = ^{cmd_instr[31:24], cmd_instr[11:4]};

  logic ok;
  always_comb begin
    case (cmd_type)
      T_WR, T_RD: ok = cp4 || cp5;
      T_LD, T_ST: ok = cp4;
      T_OP:       ok = (cp4 && op == 4'd0) || (cp5 && op <= 4'd5);
      default:    ok = 1'b0;
    endcase
  end

  assign cmd_busy   = st == S_BEAT2 || (st == S_STALL && !reached);
  assign cmd_done   = (st == S_RESP && !rej_q) || (st == S_STALL && reached);
  assign cmd_reject = st == S_RESP && rej_q;
  assign cmd_accept = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      cnt <= '0; fin <= '0; fcnt <= '0; icnt <= '0;
      fpend <= 1'b0; ipend <= 1'b0; acc_q <= 1'b0; rej_q <= 1'b0; ld_q <= 1'b0;
      nidx <= '0; cmd_rdata <= '0; fiq_n <= 1'b1; irq_n <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      acc_q <= 1'b0;
      rej_q <= 1'b0;
      if (fpend) begin
        if (fcnt == DW'(1)) begin fiq_n <= 1'b0; fpend <= 1'b0; end
        else fcnt <= fcnt - 1'b1;
      end
      if (ipend) begin
        if (icnt == DW'(1)) begin irq_n <= 1'b0; ipend <= 1'b0; end
        else icnt <= icnt - 1'b1;
      end
      case (st)
        S_IDLE: if (cmd_valid) begin
          acc_q <= ok;
          rej_q <= !ok;
          st    <= S_RESP;
          if (ok) begin
            case (cmd_type)
              T_WR: regs[ra] <= cmd_wdata;
              T_RD: cmd_rdata <= regs[ra];
              T_LD, T_ST: begin
                if (cmd_type == T_LD) regs[rl] <= cmd_wdata;
                else cmd_rdata <= regs[rl];
                ld_q <= cmd_type == T_LD;
                nidx <= rl + 1'b1;
                if (lng) st <= S_BEAT2;
              end
              default: begin
                case (op)
                  4'd0: begin fin <= cnt + opnd; st <= S_STALL; end
                  4'd1: begin
                    fpend <= opnd != '0; fcnt <= opnd;
                    if (opnd == '0) fiq_n <= 1'b0;
                  end
                  4'd2: begin
                    ipend <= opnd != '0; icnt <= opnd;
                    if (opnd == '0) irq_n <= 1'b0;
                  end
                  4'd3: begin fiq_n <= 1'b1; fpend <= 1'b0; end
                  4'd4: begin irq_n <= 1'b1; ipend <= 1'b0; end
                  default: regs[ro] <= cnt;
                endcase
              end
            endcase
          end
        end
        S_BEAT2: begin
          if (ld_q) regs[nidx] <= cmd_wdata;
          else cmd_rdata <= regs[nidx];
          st <= S_RESP;
        end
        S_STALL: if (reached) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_NOT_REJECT: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_done && cmd_reject)); // R11
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_busy && cmd_done)); // R5
  AST_REJECT_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n) go && !ok |=> cmd_reject && !cmd_accept); // R11
  AST_ACCEPT_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n) go && ok |=> cmd_accept && !cmd_reject); // R12
  AST_FIQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) go && cmd_type == T_OP && cp5 && op == 4'd3 |=> fiq_n); // R9
  AST_IRQ_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n) go && cmd_type == T_OP && cp5 && op == 4'd2 && opnd == '0 |=> !irq_n); // R7
  AST_IGNORE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid && st != S_IDLE |=> !cmd_accept && !cmd_reject); // R13
endmodule

// File: tb/tcop_timed_tb_top.sv
module tcop_timed_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_type = '0;
  logic [3:0] cmd_cpnum = '0;
  logic [31:0] cmd_instr = '0, cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic cmd_busy, cmd_done, cmd_accept, cmd_reject, fiq_n, irq_n;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] mreg [16];

  always #5 clk = ~clk;

  tcop_timed #(.DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_cpnum(cmd_cpnum), .cmd_instr(cmd_instr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .fiq_n(fiq_n), .irq_n(irq_n));

  function automatic logic [31:0] i_rt(int r);
    return 32'(r & 15) << 16;
  endfunction
  function automatic logic [31:0] i_ls(int r, bit lng);
    return (32'(r & 15) << 12) | (32'(lng) << 22);
  endfunction
  function automatic logic [31:0] i_op(int op, int r);
    return (32'(op & 15) << 20) | 32'(r & 15);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [2:0] ty, logic [3:0] cp, logic [31:0] ins, logic [31:0] wd, logic [31:0] wd2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_type = ty; cmd_cpnum = cp; cmd_instr = ins; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_wdata = wd2;
  endtask

  task automatic wr(int cp, int r, logic [31:0] v);
    send(3'd0, 4'(cp), i_rt(r), v, 32'h0);
    mreg[r] = v;
  endtask

  task automatic rd(int cp, int r, output logic [31:0] v);
    send(3'd1, 4'(cp), i_rt(r), 32'h0, 32'h0);
    v = cmd_rdata;
  endtask

  task automatic fall_after(string req, bit fast, output int k);
    k = 1;
    while ((fast ? fiq_n : irq_n) && k < 2000) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    int n, k;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fiq_n", 32'(fiq_n), 1);
    check("R1 irq_n", 32'(irq_n), 1);
    check("R1 handshake", 32'({cmd_busy, cmd_done, cmd_accept, cmd_reject}), 0);
    for (int i = 0; i < 16; i++) begin rd(4, i, v); check("R1 reg zero", v, 0); end

    wr(5, 9, 32'hDEADBEEF);
    rd(4, 9, v);
    check("R2 read value", v, 32'hDEADBEEF);
    check("R2 done", 32'(cmd_done), 1);
    check("R12 accept", 32'(cmd_accept), 1);

    for (int it = 0; it < 300; it++) begin
      int kind = $urandom_range(0, 3);
      int r = $urandom_range(0, 15);
      int cp = $urandom_range(4, 5);
      bit lng = $urandom_range(0, 1);
      logic [31:0] d0 = $urandom, d1 = $urandom;
      case (kind)
        0: begin wr(cp, r, d0); check("R2 write done", 32'(cmd_done), 1); end
        1: begin rd(cp, r, v); check("R2 random read", v, mreg[r]); end
        2: begin
          send(3'd2, 4'd4, i_ls(r, lng), d0, d1);
          mreg[r] = d0;
          if (lng) begin
            check("R4 load busy", 32'(cmd_busy), 1);
            @(negedge clk);
            mreg[(r + 1) % 16] = d1;
          end
          check("R3 load done", 32'(cmd_done), 1);
        end
        default: begin
          send(3'd3, 4'd4, i_ls(r, lng), 32'h0, 32'h0);
          check("R3 store word0", cmd_rdata, mreg[r]);
          if (lng) begin
            check("R4 store busy", 32'(cmd_busy), 1);
            @(negedge clk);
            check("R4 store word1", cmd_rdata, mreg[(r + 1) % 16]);
          end
          check("R3 store done", 32'(cmd_done), 1);
        end
      endcase
    end

    send(3'd2, 4'd4, i_ls(15, 1'b1), 32'h11111111, 32'h22222222);
    @(negedge clk);
    mreg[15] = 32'h11111111; mreg[0] = 32'h22222222;
    rd(4, 0, v); check("R4 wrap to reg0", v, 32'h22222222);
    send(3'd3, 4'd4, i_ls(15, 1'b1), 32'h0, 32'h0);
    check("R4 wrap store word0", cmd_rdata, 32'h11111111);
    @(negedge clk);
    check("R4 wrap store word1", cmd_rdata, 32'h22222222);

    foreach (mreg[i]) begin end
    wr(4, 3, 32'd7);
    send(3'd4, 4'd4, i_op(0, 3), 32'h0, 32'h0);
    n = 1;
    while (!cmd_done && n < 2000) begin check("R5 busy in stall", 32'(cmd_busy), 1); @(negedge clk); n++; end
    check("R5 stall 7", 32'(n), 7);
    wr(5, 3, 32'd0);
    send(3'd4, 4'd5, i_op(0, 3), 32'h0, 32'h0);
    check("R5 stall 0 done at T+1", 32'(cmd_done), 1);

    wr(4, 12, 32'hAAAA5555);
    wr(4, 4, 32'd6);
    send(3'd4, 4'd5, i_op(0, 4), 32'h0, 32'h0);
    cmd_valid = 1'b1; cmd_type = 3'd0; cmd_cpnum = 4'd4; cmd_instr = i_rt(12); cmd_wdata = 32'h0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R13 no accept in flight", 32'(cmd_accept), 0);
    n = 2;
    while (!cmd_done && n < 2000) begin @(negedge clk); n++; end
    check("R5 stall 6", 32'(n), 6);
    rd(4, 12, v); check("R13 ignored write", v, 32'hAAAA5555);

    wr(5, 1, 32'd4);
    send(3'd4, 4'd5, i_op(1, 1), 32'h0, 32'h0);
    fall_after("R6", 1'b1, k);
    check("R6 fiq after 4", 32'(k), 5);
    repeat (5) @(negedge clk);
    check("R6 fiq held", 32'(fiq_n), 0);
    send(3'd4, 4'd5, i_op(3, 0), 32'h0, 32'h0);
    check("R9 fiq released", 32'(fiq_n), 1);

    wr(5, 2, 32'd0);
    send(3'd4, 4'd5, i_op(2, 2), 32'h0, 32'h0);
    check("R7 irq immediate", 32'(irq_n), 0);
    send(3'd4, 4'd5, i_op(4, 0), 32'h0, 32'h0);
    check("R9 irq released", 32'(irq_n), 1);
    wr(5, 2, 32'd3);
    send(3'd4, 4'd5, i_op(2, 2), 32'h0, 32'h0);
    fall_after("R7", 1'b0, k);
    check("R7 irq after 3", 32'(k), 4);
    send(3'd4, 4'd5, i_op(4, 0), 32'h0, 32'h0);

    wr(5, 5, 32'd10);
    send(3'd4, 4'd5, i_op(1, 5), 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    send(3'd4, 4'd5, i_op(1, 5), 32'h0, 32'h0);
    fall_after("R8", 1'b1, k);
    check("R8 restarted fiq", 32'(k), 11);
    send(3'd4, 4'd5, i_op(3, 0), 32'h0, 32'h0);

    wr(5, 6, 32'd5);
    send(3'd4, 4'd5, i_op(2, 6), 32'h0, 32'h0);
    send(3'd4, 4'd5, i_op(4, 0), 32'h0, 32'h0);
    n = 0;
    for (int i = 0; i < 12; i++) begin if (!irq_n) n++; @(negedge clk); end
    check("R9 release cancels countdown", 32'(n), 0);

    for (int rep = 0; rep < 4; rep++) begin
      int gap = $urandom_range(0, 20);
      send(3'd4, 4'd5, i_op(5, 8), 32'h0, 32'h0);
      repeat (gap) @(negedge clk);
      send(3'd4, 4'd5, i_op(5, 9), 32'h0, 32'h0);
      rd(4, 8, a); rd(4, 9, b);
      mreg[8] = a; mreg[9] = b;
      check("R10 snapshot gap", b - a, 32'(gap + 2));
    end

    wr(4, 2, 32'h12345678);
    send(3'd0, 4'd6, i_rt(2), 32'h0BADF00D, 32'h0);
    check("R11 reject other number", 32'({cmd_reject, cmd_done, cmd_accept}), 32'b100);
    rd(4, 2, v); check("R11 no write", v, 32'h12345678);
    send(3'd2, 4'd5, i_ls(2, 1'b0), 32'h0BADF00D, 32'h0);
    check("R11 reject load on 5", 32'({cmd_reject, cmd_done, cmd_accept}), 32'b100);
    rd(5, 2, v); check("R11 no load", v, 32'h12345678);
    send(3'd5, 4'd4, i_rt(2), 32'h0, 32'h0);
    check("R11 reject type 5", 32'({cmd_reject, cmd_done, cmd_accept}), 32'b100);
    wr(4, 0, 32'd0);
    send(3'd4, 4'd4, i_op(1, 0), 32'h0, 32'h0);
    check("R11 reject op1 on 4", 32'({cmd_reject, cmd_done, cmd_accept}), 32'b100);
    @(negedge clk);
    check("R11 fiq untouched", 32'(fiq_n), 1);
    send(3'd4, 4'd5, i_op(7, 2), 32'h0, 32'h0);
    check("R11 reject op7 on 5", 32'({cmd_reject, cmd_done, cmd_accept}), 32'b100);
    send(3'd4, 4'd4, i_op(5, 2), 32'h0, 32'h0);
    check("R11 reject snapshot on 4", 32'(cmd_reject), 1);
    rd(4, 2, v); check("R11 no snapshot", v, 32'h12345678);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule